// File: doc/BRIEF.md
# Serial-Loaded Dual Wiper Register Bank

This block is the digital front end of a two-channel, 256-position digital potentiometer. A host writes to it over a three-wire serial link: a serial clock, an active-low select and a data line. Each write is a 10-bit word. The first two bits are a channel address and the last eight are a wiper code, and the word is sent most significant bit first. When the host releases the select line after exactly ten serial clock edges, the block decodes the address and copies the code into the addressed 8-bit wiper latch. The other latch keeps its value.

The block runs on a single system clock. The three serial pins and the shutdown pin pass through synchronizers, and the serial clock and select edges are found by comparing synchronized samples. A synchronous active-high reset puts every latch at midscale (code 128). Reset wins over any load in progress. The shutdown input is passed, registered, to the analog section. The resistor ladder is outside this block.

Top module: `wiper_serial_bank`

## Requirements
- R1: While `rst` is sampled high, every wiper latch goes to 128 (0x80) and `shdn_o` goes to 0.
- R2: A frame is the set of rising `ser_clk` edges seen while `ser_csn` is low. `ser_din` is sampled at each edge. The first two bits form the address, MSB first. The remaining eight bits form the code, MSB first. Address 0 writes the code to `wiper_o[7:0]`.
- R3: A 10-bit frame with address 1 writes its code to `wiper_o[15:8]` and leaves `wiper_o[7:0]` unchanged.
- R4: A 10-bit frame with address 2 or 3 leaves both latches unchanged.
- R5: A frame with fewer than 10 clock edges is discarded.
- R6: A frame with more than 10 clock edges is discarded.
- R7: `ser_clk` edges seen while `ser_csn` is high shift nothing. Bits left over from a discarded frame do not carry into the next frame.
- R8: If `rst` is high when `ser_csn` rises at the end of a valid frame, the latches stay at 128.
- R9: `shdn_o` follows `shdn_in` within 4 system clock cycles and has no effect on the latches.
- R10: A latch keeps its old value while `ser_csn` is still low, even after 10 edges have arrived. It changes only after `ser_csn` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_csn | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, MSB first |
| shdn_in | input | 1 | Shutdown request |
| wiper_o | output | 16 | Wiper codes; channel n is at bits [8n+7:8n] |
| shdn_o | output | 1 | Registered shutdown flag |

## Verification
The case that needs care is a reset arriving in the same cycle as a frame-end load, because both act on the wiper latches. The bench provokes it by raising `rst` while a complete 10-bit frame is still selected and holding `rst` high across the release of `ser_csn`. The expected result is that both latches read 128 afterwards and that no stale load appears once reset is removed. A second overlap occurs when a shutdown change arrives while a write is idle. The bench checks that `shdn_o` moves while both codes stay as they were.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  parameter int WIPER_W   = 8;
  parameter int ADDR_W    = 2;
  parameter int NUM_CH    = 2;
  parameter int SYNC_LEN  = 2;
  localparam int FRAME_W  = ADDR_W + WIPER_W;
  localparam int CNT_MAX  = FRAME_W + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [WIPER_W-1:0] code;
  } frame_t;

  localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1) << (WIPER_W - 1);
endpackage

// File: rtl/wsb_sync.sv
module wsb_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= INIT;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wsb_deser.sv
module wsb_deser
  import wsb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sclk_s,
  input  logic   csn_s,
  input  logic   sdi_s,
  output logic   ld_valid,
  output frame_t ld_frame
);
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic               sclk_q;
  logic               csn_q;
  logic               sclk_rise;
  logic               csn_rise;

  assign sclk_rise = sclk_s && !sclk_q;
  assign csn_rise  = csn_s && !csn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      cnt      <= '0;
      sclk_q   <= 1'b0;
      csn_q    <= 1'b1;
      ld_valid <= 1'b0;
      ld_frame <= '0;
    end else begin
      sclk_q   <= sclk_s;
      csn_q    <= csn_s;
      ld_valid <= 1'b0;
      if (csn_s) begin
        if (csn_rise && cnt == CNT_W'(FRAME_W)) begin
          ld_valid <= 1'b1;
          ld_frame <= frame_t'(sreg);
        end
        sreg <= '0;
        cnt  <= '0;
      end else if (sclk_rise) begin
        sreg <= {sreg[FRAME_W-2:0], sdi_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wsb_latches.sv
module wsb_latches
  import wsb_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  frame_t                ld_frame,
  output logic [CH*WIPER_W-1:0] wiper_o
);
  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [WIPER_W-1:0] code_q;

    always_ff @(posedge clk) begin
      if (rst) code_q <= MID_CODE;
      else if (ld_valid && ld_frame.addr == ADDR_W'(i)) code_q <= ld_frame.code;
    end

    assign wiper_o[i*WIPER_W +: WIPER_W] = code_q;
  end
endmodule

// File: rtl/wiper_serial_bank.sv
module wiper_serial_bank
  import wsb_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk,
  input  logic                  ser_csn,
  input  logic                  ser_din,
  input  logic                  shdn_in,
  output logic [CH*WIPER_W-1:0] wiper_o,
  output logic                  shdn_o
);
  logic [3:0]         pins_s;
  frame_t             ld_frame;
  logic               ld_valid;
  logic [ADDR_W-1:0]  ld_addr;
  logic [WIPER_W-1:0] ld_code;

  wsb_sync #(.N(4), .STAGES(SYNC_LEN), .INIT(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({shdn_in, ser_csn, ser_clk, ser_din}),
    .q   (pins_s)
  );

  wsb_deser u_deser (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[1]),
    .csn_s    (pins_s[2]),
    .sdi_s    (pins_s[0]),
    .ld_valid (ld_valid),
    .ld_frame (ld_frame)
  );

  assign ld_addr = ld_frame.addr;
  assign ld_code = ld_frame.code;

  wsb_latches #(.CH(CH)) u_latches (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_frame (ld_frame),
    .wiper_o  (wiper_o)
  );

  always_ff @(posedge clk) begin
    if (rst) shdn_o <= 1'b0;
    else     shdn_o <= pins_s[3];
  end
endmodule

// File: rtl/wiper_serial_bank_chk.sv
module wiper_serial_bank_chk
  import wsb_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ld_valid,
  input logic [ADDR_W-1:0]     ld_addr,
  input logic [WIPER_W-1:0]    ld_code,
  input logic [CH*WIPER_W-1:0] wiper_o,
  input logic                  shdn_o
);
  // R1 and R8: reset forces midscale and a low shutdown flag on the next edge
  a_r1_reset_midscale: assert property (@(posedge clk)
    rst |=> (wiper_o == {CH{MID_CODE}}) && !shdn_o);

  // R10: without a frame-end load the latches hold
  a_r10_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> $stable(wiper_o));

  // R4: unmapped addresses touch no latch
  a_r4_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_addr >= ADDR_W'(CH)) |=> $stable(wiper_o));

  for (genvar i = 0; i < CH; i++) begin : g_ch
    // R2 and R3: a decoded load lands in the addressed latch
    a_r2_load_lands: assert property (@(posedge clk) disable iff (rst)
      (ld_valid && ld_addr == ADDR_W'(i)) |=>
        wiper_o[i*WIPER_W +: WIPER_W] == $past(ld_code));
  end
endmodule

bind wiper_serial_bank wiper_serial_bank_chk #(.CH(CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_valid (ld_valid),
  .ld_addr  (ld_addr),
  .ld_code  (ld_code),
  .wiper_o  (wiper_o),
  .shdn_o   (shdn_o)
);

// File: tb/wiper_serial_bank_tb.sv
module wiper_serial_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_csn = 1'b1;
  logic        ser_din = 1'b0;
  logic        shdn_in = 1'b0;
  logic [15:0] wiper_o;
  logic        shdn_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] w0;
    logic [7:0] w1;
    logic       sd;
    string      tag;
    int         due;
  } item_t;

  item_t q[$];
  logic [7:0] m_w0 = 8'h80;
  logic [7:0] m_w1 = 8'h80;
  logic       m_sd = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wiper_serial_bank u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_csn(ser_csn),
    .ser_din(ser_din), .shdn_in(shdn_in), .wiper_o(wiper_o), .shdn_o(shdn_o)
  );

  // monitor: pops expected items when due and compares
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (wiper_o[7:0] !== it.w0 || wiper_o[15:8] !== it.w1 || shdn_o !== it.sd) begin
        fails++;
        $display("FAIL %s: got w0=%h w1=%h sd=%b expected w0=%h w1=%h sd=%b",
                 it.tag, wiper_o[7:0], wiper_o[15:8], shdn_o, it.w0, it.w1, it.sd);
      end
    end
  end

  task automatic expect_now(input string tag);
    item_t it;
    it.w0 = m_w0; it.w1 = m_w1; it.sd = m_sd; it.tag = tag; it.due = cyc + 1;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // drives n bits of 'bits' MSB first; mode 1: check hold before release (R10);
  // mode 2: reset held across the release (R8)
  task automatic send(input logic [15:0] bits, input int n, input int mode, input string tag);
    ser_csn = 1'b0;
    wait_clk(4);
    for (int k = n - 1; k >= 0; k--) begin
      ser_din = bits[k];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(6);
    if (mode == 1) expect_now({tag, " R10 hold before release"});
    if (mode == 2) rst = 1'b1;
    wait_clk(2);
    ser_csn = 1'b1;
    wait_clk(10);
    if (mode == 2) begin
      rst = 1'b0;
      m_w0 = 8'h80; m_w1 = 8'h80; m_sd = 1'b0;
      wait_clk(10);
    end else if (n == 10) begin
      if (bits[9:8] == 2'd0) m_w0 = bits[7:0];
      else if (bits[9:8] == 2'd1) m_w1 = bits[7:0];
    end
    expect_now(tag);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    expect_now("R1 reset midscale");
    send({6'd0, 2'd0, 8'h5A}, 10, 0, "R2 ch0 load 5A");
    send({6'd0, 2'd1, 8'hC3}, 10, 0, "R3 ch1 load C3");
    send({6'd0, 2'd0, 8'h00}, 10, 0, "R2 ch0 zero code");
    send({6'd0, 2'd0, 8'hFF}, 10, 1, "R2 ch0 full code");
    send({6'd0, 2'd2, 8'h11}, 10, 0, "R4 addr 2 ignored");
    send({6'd0, 2'd3, 8'h22}, 10, 0, "R4 addr 3 ignored");
    send({7'd0, 1'd0, 8'h33}, 9, 0, "R5 short frame");
    send({5'd0, 3'd1, 8'h44}, 11, 0, "R6 long frame");
    for (int k = 0; k < 5; k++) begin
      ser_din = 1'b1; wait_clk(4); ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0;
    end
    send({6'd0, 2'd1, 8'h0F}, 5, 0, "R7 partial frame");
    send({6'd0, 2'd1, 8'h6B}, 10, 0, "R7 clean frame after idle clocks");
    shdn_in = 1'b1; wait_clk(4); m_sd = 1'b1;
    expect_now("R9 shutdown on, codes kept");
    shdn_in = 1'b0; wait_clk(4); m_sd = 1'b0;
    expect_now("R9 shutdown off");
    send({6'd0, 2'd0, 8'hA7}, 10, 2, "R8 reset beats load");
    send({6'd0, 2'd1, 8'h01}, 10, 1, "R3 ch1 after reset");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule